// File: doc/BRIEF.md
# Tiled Integer Matrix Multiply-Accumulate Engine

This engine computes C' = beta·C + alpha·A·B for square N×N signed integer matrices that live in an external word-addressed memory. Element (i,j) of each matrix is stored at its base address plus i·N + j. Each read request fetches U consecutive words, and each write stores U consecutive words. Only one read is in flight at a time. The write port holds its request until the memory accepts it.

Work is organised at two levels. For every B×B output tile, the engine walks the shared dimension one tile pair at a time. For each pair it first copies an A tile and a B tile into on-chip buffers. It then multiplies them by stepping through G×G sub-tiles, and a combinational array forms a whole sub-tile product per cycle. These partial products are summed into a wide accumulator bank. Once all N/B tile pairs are summed, the engine reads the matching C tile, scales it, adds the scaled accumulator and writes C' back in place. The three phases never overlap. A start pulse launches a run, and a one-cycle done pulse closes it.

Top module: `gemm_tile_engine`

## Requirements
- R1: While rst is high and after it is released, rd_req, wr_en and done are 0. A run in progress when reset arrives is abandoned, and no further reads are issued until the next start.
- R2: After a run, every element at base_c + i·N + j holds the low DW bits of beta·C(i,j) + alpha·Σk A(i,k)·B(k,j), with all operands taken as signed DW-bit words.
- R3: With alpha = 0, every C' element equals beta·C(i,j) truncated to DW bits.
- R4: With beta = 0, every C' element equals alpha·(A·B)(i,j), whatever C held before.
- R5: For an output tile, all (N/B)·2·(B·B/U) A/B tile reads are issued before its first C read. The first C' write therefore follows exactly (N/B)·2·(B·B/U) + 1 reads of the run.
- R6: Every read address is a multiple of U. Each read response carries U words, with word k in rd_data bits [k·DW +: DW].
- R7: rd_req is a single-cycle pulse, and a new request is not issued before the response to the previous one has arrived on rd_valid.
- R8: While wr_en is high and wr_ready is low, wr_en, wr_addr and wr_data stay unchanged in the next cycle.
- R9: done is high for exactly one cycle, the cycle right after the clock edge that accepts the final C' write.
- R10: A run issues exactly (N/B)²·((N/B)·2 + 1)·(B·B/U) reads and (N/B)²·(B·B/U) writes.
- R11: start is ignored while a run is in progress. It is accepted whenever the engine is idle, including the cycle in which done is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches a run when idle |
| alpha | input | DW | Signed scale applied to A·B |
| beta | input | DW | Signed scale applied to C |
| base_a | input | AW | Word address of A(0,0) |
| base_b | input | AW | Word address of B(0,0) |
| base_c | input | AW | Word address of C(0,0), also the destination of C' |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | AW | First word address of the read |
| rd_valid | input | 1 | Read response strobe |
| rd_data | input | U·DW | U words returned by the read |
| wr_en | output | 1 | Write request, held until accepted |
| wr_addr | output | AW | First word address of the write |
| wr_data | output | U·DW | U words to store |
| wr_ready | input | 1 | Memory accepts the write this cycle |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
A new start can land in the very cycle that done is high. The engine must treat that cycle as idle and launch a second run straight away. The bench provokes this by raising start in the cycle where it observes done. It judges the result by requiring a second done pulse and by comparing every C' element of the second run against a reference built from the first run's output. A start raised in the middle of a run must instead leave both the done count and the results unchanged, and the bench checks that case as well.

// File: rtl/gemm_pkg.sv
package gemm_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_LREQ,
    S_LWAIT,
    S_COMP,
    S_CREQ,
    S_CWAIT,
    S_CWR
  } gemm_state_t;
endpackage

// File: rtl/gemm_tile_buf.sv
// One B x B tile held on chip; filled U words per write, read as a whole.
module gemm_tile_buf #(
  parameter int DW = 16,
  parameter int B  = 4,
  parameter int U  = 2,
  parameter int CW = $clog2(B*B/U)
) (
  input  logic                clk,
  input  logic                we,
  input  logic [CW-1:0]       widx,
  input  logic [U*DW-1:0]     wdata,
  output logic [B*B*DW-1:0]   tile
);
  always_ff @(posedge clk) begin
    if (we) begin
      for (int k = 0; k < U; k++) begin
        tile[(int'(widx)*U + k)*DW +: DW] <= wdata[k*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/gemm_subtile_mac.sv
// Combinational G x G x G product of one A sub-tile row band and one B sub-tile column band.
module gemm_subtile_mac #(
  parameter int DW   = 16,
  parameter int B    = 4,
  parameter int G    = 2,
  parameter int ACCW = 36,
  parameter int SW   = 1
) (
  input  logic [B*B*DW-1:0]       a_tile,
  input  logic [B*B*DW-1:0]       b_tile,
  input  logic [SW-1:0]           si,
  input  logic [SW-1:0]           sj,
  input  logic [SW-1:0]           sk,
  output logic signed [ACCW-1:0]  psum [G*G]
);
  for (genvar i = 0; i < G; i++) begin : g_row
    for (genvar j = 0; j < G; j++) begin : g_col
      always_comb begin
        logic signed [ACCW-1:0] ae;
        logic signed [ACCW-1:0] be;
        psum[i*G+j] = '0;
        for (int k = 0; k < G; k++) begin
          ae = ACCW'($signed(a_tile[((int'(si)*G + i)*B + int'(sk)*G + k)*DW +: DW]));
          be = ACCW'($signed(b_tile[((int'(sk)*G + k)*B + int'(sj)*G + j)*DW +: DW]));
          psum[i*G+j] = psum[i*G+j] + ae * be;
        end
      end
    end
  end
endmodule

// File: rtl/gemm_tile_engine.sv
module gemm_tile_engine
  import gemm_pkg::*;
#(
  parameter int DW = 16,
  parameter int N  = 8,
  parameter int B  = 4,
  parameter int G  = 2,
  parameter int U  = 2,
  parameter int AW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [DW-1:0]   alpha,
  input  logic [DW-1:0]   beta,
  input  logic [AW-1:0]   base_a,
  input  logic [AW-1:0]   base_b,
  input  logic [AW-1:0]   base_c,
  output logic            rd_req,
  output logic [AW-1:0]   rd_addr,
  input  logic            rd_valid,
  input  logic [U*DW-1:0] rd_data,
  output logic            wr_en,
  output logic [AW-1:0]   wr_addr,
  output logic [U*DW-1:0] wr_data,
  input  logic            wr_ready,
  output logic            done
);
  localparam int NT   = N / B;
  localparam int SUB  = B / G;
  localparam int CPR  = B / U;
  localparam int TCH  = B * B / U;
  localparam int CW   = $clog2(TCH);
  localparam int SW   = (SUB > 1) ? $clog2(SUB) : 1;
  localparam int TW   = (NT > 1) ? $clog2(NT) : 1;
  localparam int IW   = $clog2(B * B);
  localparam int ACCW = 2 * DW + $clog2(N) + 1;
  localparam int RW   = ACCW + DW + 1;
  localparam int CMPW = 3 * SW;

  gemm_state_t st;
  logic [CW:0]    ld_cnt;
  logic [CW-1:0]  c_cnt;
  logic [CMPW-1:0] cmp_cnt;
  logic [TW-1:0]  ti, tj, kt;
  logic [SW-1:0]  si, sj, sk;
  logic [AW-1:0]  ld_addr, c_addr;
  logic [31:0]    lr, lc, cr, cc;
  logic [B*B*DW-1:0] tile_a, tile_b;
  logic signed [ACCW-1:0] acc [B*B];
  logic signed [ACCW-1:0] psum [G*G];
  logic [IW-1:0]  aix [G*G];
  logic [IW-1:0]  cix [U];
  logic [DW-1:0]  cres [U];
  logic           we_a, we_b, acc_clr, last_chunk;

  assign si = cmp_cnt[3*SW-1:2*SW];
  assign sj = cmp_cnt[2*SW-1:SW];
  assign sk = cmp_cnt[SW-1:0];

  // Row-major address generation for tile loads and for the C phase.
  always_comb begin
    lr = 32'(ld_cnt[CW-1:0]) / CPR;
    lc = (32'(ld_cnt[CW-1:0]) % CPR) * U;
    if (!ld_cnt[CW])
      ld_addr = base_a + AW'((32'(ti)*B + lr)*N + 32'(kt)*B + lc);
    else
      ld_addr = base_b + AW'((32'(kt)*B + lr)*N + 32'(tj)*B + lc);
    cr = 32'(c_cnt) / CPR;
    cc = (32'(c_cnt) % CPR) * U;
    c_addr = base_c + AW'((32'(ti)*B + cr)*N + 32'(tj)*B + cc);
  end

  assign we_a = (st == S_LWAIT) && rd_valid && !ld_cnt[CW];
  assign we_b = (st == S_LWAIT) && rd_valid &&  ld_cnt[CW];

  gemm_tile_buf #(.DW(DW), .B(B), .U(U), .CW(CW)) u_buf_a (
    .clk(clk), .we(we_a), .widx(ld_cnt[CW-1:0]), .wdata(rd_data), .tile(tile_a));
  gemm_tile_buf #(.DW(DW), .B(B), .U(U), .CW(CW)) u_buf_b (
    .clk(clk), .we(we_b), .widx(ld_cnt[CW-1:0]), .wdata(rd_data), .tile(tile_b));

  gemm_subtile_mac #(.DW(DW), .B(B), .G(G), .ACCW(ACCW), .SW(SW)) u_mac (
    .a_tile(tile_a), .b_tile(tile_b), .si(si), .sj(sj), .sk(sk), .psum(psum));

  for (genvar i = 0; i < G; i++) begin : g_aix_r
    for (genvar j = 0; j < G; j++) begin : g_aix_c
      assign aix[i*G+j] = IW'((32'(si)*G + i)*B + 32'(sj)*G + j);
    end
  end

  // Final scaling of one U-word chunk of the C tile.
  for (genvar k = 0; k < U; k++) begin : g_scale
    assign cix[k] = IW'(cr*B + cc + k);
    always_comb begin
      cres[k] = DW'(RW'($signed(alpha)) * RW'(acc[cix[k]])
                  + RW'($signed(beta)) * RW'($signed(rd_data[k*DW +: DW])));
    end
  end

  assign last_chunk = (c_cnt == CW'(TCH - 1));
  assign acc_clr = ((st == S_IDLE) && start) || ((st == S_CWR) && wr_ready && last_chunk);

  always_ff @(posedge clk) begin
    if (acc_clr) begin
      for (int p = 0; p < B*B; p++) acc[p] <= '0;
    end else if (st == S_COMP) begin
      for (int p = 0; p < G*G; p++) acc[aix[p]] <= acc[aix[p]] + psum[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      rd_req  <= 1'b0;
      rd_addr <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      done    <= 1'b0;
      ld_cnt  <= '0;
      c_cnt   <= '0;
      cmp_cnt <= '0;
      ti      <= '0;
      tj      <= '0;
      kt      <= '0;
    end else begin
      rd_req <= 1'b0;
      done   <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          ti <= '0; tj <= '0; kt <= '0; ld_cnt <= '0;
          st <= S_LREQ;
        end
        S_LREQ: begin
          rd_req  <= 1'b1;
          rd_addr <= ld_addr;
          st      <= S_LWAIT;
        end
        S_LWAIT: if (rd_valid) begin
          if (ld_cnt == (CW+1)'(2*TCH - 1)) begin
            ld_cnt  <= '0;
            cmp_cnt <= '0;
            st      <= S_COMP;
          end else begin
            ld_cnt <= ld_cnt + 1'b1;
            st     <= S_LREQ;
          end
        end
        S_COMP: begin
          if (cmp_cnt == CMPW'(SUB*SUB*SUB - 1)) begin
            if (kt == TW'(NT - 1)) begin
              c_cnt <= '0;
              st    <= S_CREQ;
            end else begin
              kt <= kt + 1'b1;
              st <= S_LREQ;
            end
          end else begin
            cmp_cnt <= cmp_cnt + 1'b1;
          end
        end
        S_CREQ: begin
          rd_req  <= 1'b1;
          rd_addr <= c_addr;
          st      <= S_CWAIT;
        end
        S_CWAIT: if (rd_valid) begin
          wr_en   <= 1'b1;
          wr_addr <= c_addr;
          for (int k = 0; k < U; k++) wr_data[k*DW +: DW] <= cres[k];
          st <= S_CWR;
        end
        S_CWR: if (wr_ready) begin
          wr_en <= 1'b0;
          if (last_chunk) begin
            kt <= '0; ld_cnt <= '0;
            if (ti == TW'(NT - 1) && tj == TW'(NT - 1)) begin
              done <= 1'b1;
              st   <= S_IDLE;
            end else begin
              if (tj == TW'(NT - 1)) begin
                tj <= '0;
                ti <= ti + 1'b1;
              end else begin
                tj <= tj + 1'b1;
              end
              st <= S_LREQ;
            end
          end else begin
            c_cnt <= c_cnt + 1'b1;
            st    <= S_CREQ;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gemm_tile_engine_chk.sv
module gemm_tile_engine_chk #(
  parameter int DW = 16,
  parameter int U  = 2,
  parameter int AW = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            rd_req,
  input logic [AW-1:0]   rd_addr,
  input logic            rd_valid,
  input logic            wr_en,
  input logic [AW-1:0]   wr_addr,
  input logic [U*DW-1:0] wr_data,
  input logic            wr_ready,
  input logic            done
);
  logic pend;

  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else if (rd_req) pend <= 1'b1;
    else if (rd_valid) pend <= 1'b0;
  end

  p_req_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);

  p_one_outstanding_r7: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> !pend);

  p_aligned_r6: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> (rd_addr % AW'(U)) == '0);

  p_wr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_ready) |=> (wr_en && $stable(wr_addr) && $stable(wr_data)));

  p_no_read_while_write_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !rd_req);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_after_accept_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(wr_en && wr_ready));

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!rd_req && !wr_en && !done));
endmodule

bind gemm_tile_engine gemm_tile_engine_chk #(.DW(DW), .U(U), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready), .done(done));

// File: tb/gemm_tile_engine_bench.sv
`timescale 1ns/1ps
module gemm_tile_engine_bench;
  localparam int DW = 16, N = 8, B = 4, G = 2, U = 2, AW = 16;
  localparam int NT = N / B, TCH = B * B / U;
  localparam int BA = 0, BB = 64, BC = 128, MEMW = 192;
  localparam int NV = 6;
  // alpha, beta, seed, read latency, write stall mode, mid-run start
  localparam int TV [NV][6] = '{
    '{ 3,  2, 11, 1, 0, 0},
    '{ 0,  3, 22, 2, 1, 0},
    '{ 2,  0, 33, 0, 2, 0},
    '{-4, -3, 44, 3, 1, 1},
    '{ 1,  1, 55, 0, 0, 0},
    '{-1,  2, 66, 2, 2, 1}
  };

  logic clk = 0, rst = 1, start = 0;
  logic [DW-1:0] alpha = 0, beta = 0;
  logic [AW-1:0] base_a = BA, base_b = BB, base_c = BC;
  logic rd_req, rd_valid = 0, wr_en, wr_ready = 0, done;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [U*DW-1:0] rd_data = '0, wr_data;

  gemm_tile_engine #(.DW(DW), .N(N), .B(B), .G(G), .U(U), .AW(AW)) u_gemm_tile_engine (
    .clk(clk), .rst(rst), .start(start), .alpha(alpha), .beta(beta),
    .base_a(base_a), .base_b(base_b), .base_c(base_c),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready), .done(done));

  always #10 clk = ~clk;

  logic signed [DW-1:0] mem [MEMW];
  logic signed [DW-1:0] expv [N*N];
  int cyc = 0, lat = 1, stall = 0;
  int pend = 0, cnt = 0, raddr = 0;
  int n_reads = 0, rd_before_wr = 0, seen_wr = 0, misaligned = 0, n_writes = 0;
  int n_done = 0, done_cyc = -1, last_wr_cyc = -1;
  int total = 0, fails = 0;

  // Memory model and port monitor, evaluated at the falling edge.
  always @(negedge clk) begin
    cyc++;
    rd_valid = 0;
    if (pend != 0) begin
      if (cnt == 0) begin
        rd_valid = 1;
        for (int k = 0; k < U; k++) rd_data[k*DW +: DW] = mem[raddr + k];
        pend = 0;
      end else cnt--;
    end
    if (rd_req) begin
      pend = 1; cnt = lat; raddr = int'(rd_addr); n_reads++;
      if (seen_wr == 0) rd_before_wr++;
      if (int'(rd_addr) % U != 0) misaligned++;
    end
    case (stall)
      1: wr_ready = (cyc % 2 == 0);
      2: wr_ready = (cyc % 3 == 0);
      default: wr_ready = 1;
    endcase
    if (wr_en && wr_ready) begin
      for (int k = 0; k < U; k++) mem[int'(wr_addr) + k] = wr_data[k*DW +: DW];
      n_writes++; seen_wr = 1; last_wr_cyc = cyc;
    end
    if (done) begin n_done++; done_cyc = cyc; end
    if (cyc > 190000) begin
      fails++; total++;
      $display("FAIL watchdog: got %0d cycles expected below 190000", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic tick(); @(negedge clk); #2; endtask

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic fill(int seed);
    int s = seed;
    for (int a = 0; a < MEMW; a++) begin
      s = s * 1103515245 + 12345;
      mem[a] = DW'(((s >>> 16) & 31) - 16);
    end
  endtask

  task automatic calc(int al, int be);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        int sum = 0;
        for (int k = 0; k < N; k++) sum += int'(mem[BA + i*N + k]) * int'(mem[BB + k*N + j]);
        expv[i*N + j] = DW'(be * int'(mem[BC + i*N + j]) + al * sum);
      end
  endtask

  task automatic clear_stats();
    n_reads = 0; rd_before_wr = 0; seen_wr = 0; misaligned = 0; n_writes = 0;
  endtask

  task automatic pulse_start();
    start = 1; tick(); start = 0;
  endtask

  // Returns when done has been seen (in the tick where it is high).
  task automatic wait_done(int d0, output bit ok);
    int w = 0;
    while (n_done == d0 && w < 30000) begin tick(); w++; end
    ok = (n_done != d0);
  endtask

  task automatic check_result(string req);
    int bad = 0;
    for (int e = 0; e < N*N; e++) begin
      chk(mem[BC + e] == expv[e], req, $sformatf("C' element %0d", e), int'(mem[BC + e]), int'(expv[e]));
    end
  endtask

  task automatic check_counts();
    chk(rd_before_wr == NT*2*TCH + 1, "R5", "reads before first write", rd_before_wr, NT*2*TCH + 1);
    chk(n_reads == NT*NT*(NT*2 + 1)*TCH, "R10", "read count", n_reads, NT*NT*(NT*2 + 1)*TCH);
    chk(n_writes == NT*NT*TCH, "R10", "write count", n_writes, NT*NT*TCH);
    chk(misaligned == 0, "R6", "misaligned reads", misaligned, 0);
  endtask

  task automatic run_vec(int v);
    int d0; bit ok; string req;
    alpha = DW'(TV[v][0]); beta = DW'(TV[v][1]);
    lat = TV[v][3]; stall = TV[v][4];
    fill(TV[v][2]);
    calc(TV[v][0], TV[v][1]);
    req = (TV[v][0] == 0) ? "R3" : (TV[v][1] == 0) ? "R4" : "R2";
    clear_stats();
    d0 = n_done;
    pulse_start();
    if (TV[v][5] != 0) begin
      repeat (100) tick();
      pulse_start();   // R11: must be ignored mid-run
    end
    wait_done(d0, ok);
    chk(ok, "R9", "done seen", int'(ok), 1);
    chk(done_cyc == last_wr_cyc + 1, "R9", "done cycle after last write", done_cyc, last_wr_cyc + 1);
    repeat (300) tick();
    chk(n_done - d0 == 1, TV[v][5] != 0 ? "R11" : "R9", "done pulses per run", n_done - d0, 1);
    check_result(req);
    check_counts();
  endtask

  initial begin
    bit ok;
    int d0, r0;
    repeat (4) tick();
    // R1: outputs quiet during and after reset
    chk(!rd_req && !wr_en && !done, "R1", "outputs during reset", {rd_req, wr_en, done}, 0);
    rst = 0; tick();
    chk(!rd_req && !wr_en && !done, "R1", "outputs after reset", {rd_req, wr_en, done}, 0);

    for (int v = 0; v < NV; v++) run_vec(v);

    // R1: reset in the middle of a run abandons it
    lat = 1; stall = 0; fill(77); clear_stats();
    d0 = n_done;
    pulse_start();
    repeat (60) tick();
    rst = 1; repeat (3) tick();
    chk(!rd_req && !wr_en && !done, "R1", "outputs under mid-run reset", {rd_req, wr_en, done}, 0);
    rst = 0; pend = 0;
    r0 = n_reads;
    repeat (400) tick();
    chk(n_reads == r0, "R1", "reads after abandoned run", n_reads - r0, 0);
    chk(n_done == d0, "R1", "done after abandoned run", n_done - d0, 0);

    // R11: start raised in the cycle done is high launches the next run
    alpha = DW'(2); beta = DW'(-1); lat = 1; stall = 1;
    fill(88); calc(2, -1); clear_stats();
    d0 = n_done;
    pulse_start();
    wait_done(d0, ok);
    start = 1;                  // same cycle as done
    chk(ok, "R11", "first back-to-back done", int'(ok), 1);
    check_result("R2");
    alpha = DW'(1); beta = DW'(1);
    calc(1, 1);
    tick(); start = 0;
    clear_stats();
    d0 = n_done;
    wait_done(d0, ok);
    chk(ok, "R11", "second run started in done cycle", int'(ok), 1);
    repeat (20) tick();
    check_result("R11");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule